// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Control Registers

This block holds the software-visible control state for bus-master DMA on a two-channel disk interface. Each channel owns a command byte, a status byte and a 32-bit descriptor-table pointer. Software reaches them through a byte-addressed write port with an access-size code and an independent combinational read port. When a command write flips a channel's run bit, the block emits a one-cycle start request to the drive currently selected on that channel, carrying the channel's descriptor pointer. When the run bit is cleared, it emits a one-cycle abort request to that drive.

The DMA engine reports completion per channel on a done input, with an optional failure qualifier. A completion stops the channel, drops its active flag and raises its interrupt flag. The interrupt output is the OR of the two channels' interrupt flags. Fields follow mixed access rules. The active flag is read-only. The interrupt and failure flags are cleared by writing 1. The direction bit is frozen while a transfer runs. The pointer's two low bits always read zero. Writes are accepted only when both the I/O enable and the bus-master enable are high.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, each status byte reads 0x60 and every command byte and pointer reads 0. The start, abort, error and interrupt outputs are low.
- R2: Channel c occupies byte offsets 8c to 8c+7: command at +0, status at +2, pointer at +4..+7 in little-endian order. Offsets +1 and +3 read 0, and writes to them are ignored without error. rd_data returns the four bytes starting at rd_addr, least significant first, and bytes past the last offset read 0.
- R3: Command bit 0 is the run bit and bit 3 is the direction bit. All other command bits read 0. While the stored run bit is 1, a command write leaves the direction bit unchanged.
- R4: A command write that changes run from 0 to 1 sets status bit 0 (active). In the next cycle it raises start_pulse for one cycle with start_chan, with start_drive equal to drive_sel of that channel at the write, and with start_ptr equal to the channel's pointer.
- R5: A command write that changes run from 1 to 0 clears the active bit. In the next cycle it raises abort_pulse for one cycle with abort_chan and abort_drive.
- R6: Status bit 0 (active) ignores writes. Bit 1 (failure) and bit 2 (interrupt) clear only when a 1 is written over a set bit; writing 0 leaves them as they are. Bits 6:5 are freely written. Bits 7, 4 and 3 read 0.
- R7: A pointer write stores wr_data with bits 1:0 forced to 0.
- R8: While io_en or bm_en is low, a write changes no register, raises no pulse and raises no error.
- R9: Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes; code 3 is illegal. An accepted write is illegal in three cases: it uses code 3, it targets command or status with other than one byte, or it targets the pointer with other than four bytes at +4. Any write to +5..+7 is also illegal. An illegal write raises acc_err for one cycle in the next cycle and changes nothing.
- R10: xfer_done[c] clears run and active of channel c and sets its interrupt bit. With xfer_fail[c] it also sets the failure bit. These updates take precedence over a write to the same bits in the same cycle.
- R11: irq equals the OR of both channels' interrupt bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | I/O-space decode enable |
| bm_en | input | 1 | Bus-master enable |
| wr_valid | input | 1 | Write request this cycle |
| wr_addr | input | 4 | Write byte offset |
| wr_size | input | 2 | Write size code (0 byte, 1 half, 2 word, 3 illegal) |
| wr_data | input | 32 | Write data, least significant byte at wr_addr |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 32 | Four bytes from rd_addr upward |
| drive_sel | input | 2 | Selected drive per channel |
| xfer_done | input | 2 | Per-channel transfer completion |
| xfer_fail | input | 2 | Per-channel failure qualifier for completion |
| start_pulse | output | 1 | One-cycle start request |
| start_chan | output | 1 | Channel of the start request |
| start_drive | output | 1 | Drive of the start request |
| start_ptr | output | 32 | Descriptor pointer for the start request |
| abort_pulse | output | 1 | One-cycle abort request |
| abort_chan | output | 1 | Channel of the abort request |
| abort_drive | output | 1 | Drive of the abort request |
| acc_err | output | 1 | One-cycle illegal-access flag |
| irq | output | 1 | Interrupt, OR of both interrupt bits |

## Verification
A completion from the DMA engine and a software write to the same channel's status or command byte can land in the same clock edge. The two then compete for the interrupt, active and run bits. The bench provokes this directly: it raises xfer_done in the cycle of a write-1-to-clear of the interrupt bit, and it also lets random completions coincide with random command and status writes. It then reads the bytes back and judges them against a model that applies the write first and the completion on top. The interrupt must end set and run and active must end clear.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int PTR_W     = 32;
    localparam int OFF_W     = 3;
    localparam int RUN_BIT   = 0;
    localparam int DIR_BIT   = 3;

    localparam logic [OFF_W-1:0] OFF_CMD = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STS = 3'd2;
    localparam logic [OFF_W-1:0] OFF_PTR = 3'd4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CMD  = 2'd1,
        RK_STS  = 2'd2,
        RK_PTR  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic      bad;
    } acc_dec_t;

    typedef struct packed {
        logic dir;
        logic run;
    } cmd_t;

    typedef struct packed {
        logic [1:0] cap;
        logic       intr;
        logic       fail;
        logic       act;
    } sts_t;

    localparam sts_t STS_RST = '{cap: 2'b11, intr: 1'b0, fail: 1'b0, act: 1'b0};

    function automatic acc_dec_t decode_off(logic [OFF_W-1:0] off, acc_size_e sz);
        acc_dec_t d;
        d.kind = RK_NONE;
        d.bad  = 1'b0;
        case (off)
            OFF_CMD: begin d.kind = RK_CMD; d.bad = (sz != SZ_BYTE); end
            OFF_STS: begin d.kind = RK_STS; d.bad = (sz != SZ_BYTE); end
            OFF_PTR: begin d.kind = RK_PTR; d.bad = (sz != SZ_WORD); end
            3'd1, 3'd3: d.kind = RK_NONE;
            default: d.bad = 1'b1;
        endcase
        if (sz == SZ_BAD) d.bad = 1'b1;
        if (d.bad) d.kind = RK_NONE;
        return d;
    endfunction

    function automatic logic [7:0] cmd_byte(cmd_t c);
        logic [7:0] b;
        b = 8'h00;
        b[RUN_BIT] = c.run;
        b[DIR_BIT] = c.dir;
        return b;
    endfunction

    function automatic logic [7:0] sts_byte(sts_t s);
        return {1'b0, s.cap, 2'b00, s.intr, s.fail, s.act};
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 1
) (
    input  logic            wr_valid,
    input  logic            io_en,
    input  logic            bm_en,
    input  logic [AW-1:0]   wr_addr,
    input  acc_size_e       wr_size,
    output reg_kind_e       wr_kind,
    output logic [CW-1:0]   wr_ch,
    output logic            wr_bad
);

    acc_dec_t dec;
    logic     gate;

    always_comb begin
        dec     = decode_off(wr_addr[OFF_W-1:0], wr_size);
        gate    = wr_valid && io_en && bm_en;
        wr_kind = gate ? dec.kind : RK_NONE;
        wr_bad  = gate && dec.bad;
        wr_ch   = wr_addr[AW-1:OFF_W];
    end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              wr_sts,
    input  logic              wr_ptr,
    input  logic [PTR_W-1:0]  wr_data,
    input  logic              drive_in,
    input  logic              done_in,
    input  logic              fail_in,
    output cmd_t              cmd_q,
    output sts_t              sts_q,
    output logic [PTR_W-1:0]  ptr_q,
    output logic              go_q,
    output logic              stop_q,
    output logic              drv_q
);

    cmd_t             cmd_n;
    sts_t             sts_n;
    logic [PTR_W-1:0] ptr_n;
    logic             go_n;
    logic             stop_n;

    always_comb begin
        cmd_n  = cmd_q;
        sts_n  = sts_q;
        ptr_n  = ptr_q;
        go_n   = 1'b0;
        stop_n = 1'b0;

        if (wr_cmd) begin
            cmd_n.run = wr_data[RUN_BIT];
            cmd_n.dir = cmd_q.run ? cmd_q.dir : wr_data[DIR_BIT];
            if (!cmd_q.run && wr_data[RUN_BIT]) begin
                go_n      = 1'b1;
                sts_n.act = 1'b1;
            end
            if (cmd_q.run && !wr_data[RUN_BIT]) begin
                stop_n    = 1'b1;
                sts_n.act = 1'b0;
            end
        end

        if (wr_sts) begin
            sts_n.cap  = wr_data[6:5];
            sts_n.intr = sts_q.intr & ~wr_data[2];
            sts_n.fail = sts_q.fail & ~wr_data[1];
        end

        if (wr_ptr) begin
            ptr_n = {wr_data[PTR_W-1:2], 2'b00};
        end

        // completion is applied on top of any same-cycle write
        if (done_in) begin
            cmd_n.run  = 1'b0;
            sts_n.act  = 1'b0;
            sts_n.intr = 1'b1;
            if (fail_in) sts_n.fail = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            sts_q  <= STS_RST;
            ptr_q  <= '0;
            go_q   <= 1'b0;
            stop_q <= 1'b0;
            drv_q  <= 1'b0;
        end else begin
            cmd_q  <= cmd_n;
            sts_q  <= sts_n;
            ptr_q  <= ptr_n;
            go_q   <= go_n;
            stop_q <= stop_n;
            if (go_n || stop_n) drv_q <= drive_in;
        end
    end

endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux #(
    parameter int NB = 16,
    parameter int AW = 4
) (
    input  logic [NB*8-1:0] img,
    input  logic [AW-1:0]   rd_addr,
    output logic [31:0]     rd_data
);

    localparam logic [AW:0] NB_L = (AW+1)'(NB);

    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic [AW:0] idx;
        assign idx = {1'b0, rd_addr} + (AW+1)'(k);
        assign rd_data[k*8 +: 8] = (idx < NB_L) ? img[{idx, 3'b000} +: 8] : 8'h00;
    end

endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      io_en,
    input  logic                      bm_en,
    input  logic                      wr_valid,
    input  logic [$clog2(N_CH)+2:0]   wr_addr,
    input  logic [1:0]                wr_size,
    input  logic [31:0]               wr_data,
    input  logic [$clog2(N_CH)+2:0]   rd_addr,
    output logic [31:0]               rd_data,
    input  logic [N_CH-1:0]           drive_sel,
    input  logic [N_CH-1:0]           xfer_done,
    input  logic [N_CH-1:0]           xfer_fail,
    output logic                      start_pulse,
    output logic [$clog2(N_CH)-1:0]   start_chan,
    output logic                      start_drive,
    output logic [31:0]               start_ptr,
    output logic                      abort_pulse,
    output logic [$clog2(N_CH)-1:0]   abort_chan,
    output logic                      abort_drive,
    output logic                      acc_err,
    output logic                      irq
);

    localparam int CW = $clog2(N_CH);
    localparam int AW = CW + OFF_W;
    localparam int NB = N_CH * 8;

    reg_kind_e        wr_kind;
    logic [CW-1:0]    wr_ch;
    logic             wr_bad;

    cmd_t             cmd_q [N_CH];
    sts_t             sts_q [N_CH];
    logic [PTR_W-1:0] ptr_q [N_CH];
    logic [N_CH-1:0]  go_q;
    logic [N_CH-1:0]  stop_q;
    logic [N_CH-1:0]  drv_q;
    logic [NB*8-1:0]  img;

    bmdma_decode #(.AW(AW), .CW(CW)) u_dec (
        .wr_valid (wr_valid),
        .io_en    (io_en),
        .bm_en    (bm_en),
        .wr_addr  (wr_addr),
        .wr_size  (acc_size_e'(wr_size)),
        .wr_kind  (wr_kind),
        .wr_ch    (wr_ch),
        .wr_bad   (wr_bad)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic hit;
        assign hit = (wr_ch == CW'(c));

        bmdma_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_cmd   (hit && wr_kind == RK_CMD),
            .wr_sts   (hit && wr_kind == RK_STS),
            .wr_ptr   (hit && wr_kind == RK_PTR),
            .wr_data  (wr_data),
            .drive_in (drive_sel[c]),
            .done_in  (xfer_done[c]),
            .fail_in  (xfer_fail[c]),
            .cmd_q    (cmd_q[c]),
            .sts_q    (sts_q[c]),
            .ptr_q    (ptr_q[c]),
            .go_q     (go_q[c]),
            .stop_q   (stop_q[c]),
            .drv_q    (drv_q[c])
        );

        assign img[(c*8+0)*8 +: 8]  = cmd_byte(cmd_q[c]);
        assign img[(c*8+1)*8 +: 8]  = 8'h00;
        assign img[(c*8+2)*8 +: 8]  = sts_byte(sts_q[c]);
        assign img[(c*8+3)*8 +: 8]  = 8'h00;
        assign img[(c*8+4)*8 +: 32] = ptr_q[c];
    end

    bmdma_rdmux #(.NB(NB), .AW(AW)) u_rd (
        .img     (img),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        start_pulse = 1'b0;
        start_chan  = '0;
        start_drive = 1'b0;
        start_ptr   = '0;
        abort_pulse = 1'b0;
        abort_chan  = '0;
        abort_drive = 1'b0;
        irq         = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            irq = irq | sts_q[c].intr;
            if (go_q[c]) begin
                start_pulse = 1'b1;
                start_chan  = CW'(c);
                start_drive = drv_q[c];
                start_ptr   = ptr_q[c];
            end
            if (stop_q[c]) begin
                abort_pulse = 1'b1;
                abort_chan  = CW'(c);
                abort_drive = drv_q[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_err <= 1'b0;
        else     acc_err <= wr_bad;
    end

endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
    parameter int N_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              io_en,
    input logic              bm_en,
    input logic              wr_valid,
    input logic [N_CH-1:0]   xfer_done,
    input logic              start_pulse,
    input logic              abort_pulse,
    input logic [31:0]       start_ptr,
    input logic              acc_err,
    input logic              irq
);

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && abort_pulse)) else $error("start and abort together"); // R4

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(wr_valid && io_en && bm_en)) else $error("start without write"); // R4

    AST_ABORT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> $past(wr_valid && io_en && bm_en)) else $error("abort without write"); // R5

    AST_START_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (start_ptr[1:0] == 2'b00)) else $error("unaligned pointer"); // R7

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(io_en && bm_en) |=> !(start_pulse || abort_pulse || acc_err)) else $error("activity while disabled"); // R8

    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> $past(wr_valid)) else $error("error without write"); // R9

    AST_IRQ_RISE_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(xfer_done != '0)) else $error("irq rose without completion"); // R10

endmodule

bind bmdma_regfile bmdma_regfile_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .io_en       (io_en),
    .bm_en       (bm_en),
    .wr_valid    (wr_valid),
    .xfer_done   (xfer_done),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .start_ptr   (start_ptr),
    .acc_err     (acc_err),
    .irq         (irq)
);

// File: tb/tb_bmdma_regfile.sv
module tb_bmdma_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_en, bm_en, wr_valid;
    logic [3:0]  wr_addr, rd_addr;
    logic [1:0]  wr_size;
    logic [31:0] wr_data, rd_data;
    logic [1:0]  drive_sel, xfer_done, xfer_fail;
    logic        start_pulse, start_chan, start_drive;
    logic [31:0] start_ptr;
    logic        abort_pulse, abort_chan, abort_drive, acc_err, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0]  m_cmd [2];
    logic [7:0]  m_sts [2];
    logic [31:0] m_ptr [2];

    always #10 clk = ~clk;

    bmdma_regfile #(.N_CH(2)) dut (
        .clk(clk), .rst(rst), .io_en(io_en), .bm_en(bm_en),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .drive_sel(drive_sel), .xfer_done(xfer_done), .xfer_fail(xfer_fail),
        .start_pulse(start_pulse), .start_chan(start_chan), .start_drive(start_drive),
        .start_ptr(start_ptr), .abort_pulse(abort_pulse), .abort_chan(abort_chan),
        .abort_drive(abort_drive), .acc_err(acc_err), .irq(irq)
    );

    task automatic chk(input string ctx, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", ctx, req, act, exp);
        end
    endtask

    function automatic bit is_bad(input logic [2:0] off, input logic [1:0] sz);
        if (sz == 2'd3) return 1'b1;
        if (off == 3'd5 || off == 3'd6 || off == 3'd7) return 1'b1;
        if ((off == 3'd0 || off == 3'd2) && sz != 2'd0) return 1'b1;
        if (off == 3'd4 && sz != 2'd2) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] sts_after_write(input logic [7:0] o, input logic [7:0] d);
        return {1'b0, d[6:5], 2'b00, o[2] & ~d[2], o[1] & ~d[1], o[0]};
    endfunction

    task automatic check_regs(input string ctx);
        for (int c = 0; c < 2; c++) begin
            rd_addr = 4'(c * 8);
            #1;
            chk(ctx, "R3 cmd", {24'h0, rd_data[7:0]}, {24'h0, m_cmd[c]});
            chk(ctx, "R6 sts", {8'h0, rd_data[23:16], 8'h0}, {8'h0, m_sts[c], 8'h0});
            chk(ctx, "R2 reserved", {16'h0, rd_data[31:24], rd_data[15:8]}, 32'h0);
            rd_addr = 4'(c * 8 + 4);
            #1;
            chk(ctx, "R7 ptr", rd_data, m_ptr[c]);
        end
        chk(ctx, "R11 irq", {31'h0, irq}, {31'h0, m_sts[0][2] | m_sts[1][2]});
    endtask

    task automatic step(input string ctx, input bit v, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic [1:0] dn, input logic [1:0] fl);
        bit       gate, e_st, e_ab, e_err;
        logic     e_ch, e_drv;
        logic [31:0] e_ptr;
        int       ch;
        logic [2:0] off;
        logic [7:0] nv;
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_size = sz; wr_data = d;
        xfer_done = dn; xfer_fail = fl;
        gate = v && io_en && bm_en;
        e_st = 0; e_ab = 0; e_err = 0; e_ch = 0; e_drv = 0; e_ptr = 0;
        ch = int'(a[3]); off = a[2:0];
        if (gate && is_bad(off, sz)) e_err = 1;
        else if (gate) begin
            case (off)
                3'd0: begin
                    nv = d[7:0] & 8'h09;
                    if (m_cmd[ch][0]) nv[3] = m_cmd[ch][3];
                    if (!m_cmd[ch][0] && nv[0]) begin
                        e_st = 1; m_sts[ch][0] = 1'b1;
                        e_ch = a[3]; e_drv = drive_sel[ch]; e_ptr = m_ptr[ch];
                    end
                    if (m_cmd[ch][0] && !nv[0]) begin
                        e_ab = 1; m_sts[ch][0] = 1'b0;
                        e_ch = a[3]; e_drv = drive_sel[ch];
                    end
                    m_cmd[ch] = nv;
                end
                3'd2: m_sts[ch] = sts_after_write(m_sts[ch], d[7:0]);
                3'd4: m_ptr[ch] = {d[31:2], 2'b00};
                default: ;
            endcase
        end
        for (int c = 0; c < 2; c++) begin
            if (dn[c]) begin
                m_cmd[c][0] = 1'b0; m_sts[c][0] = 1'b0; m_sts[c][2] = 1'b1;
                if (fl[c]) m_sts[c][1] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        chk(ctx, "R4 start", {31'h0, start_pulse}, {31'h0, e_st});
        chk(ctx, "R5 abort", {31'h0, abort_pulse}, {31'h0, e_ab});
        chk(ctx, "R9 err", {31'h0, acc_err}, {31'h0, e_err});
        if (e_st) begin
            chk(ctx, "R4 chan", {31'h0, start_chan}, {31'h0, e_ch});
            chk(ctx, "R4 drive", {31'h0, start_drive}, {31'h0, e_drv});
            chk(ctx, "R4 ptr", start_ptr, e_ptr);
        end
        if (e_ab) begin
            chk(ctx, "R5 chan", {31'h0, abort_chan}, {31'h0, e_ch});
            chk(ctx, "R5 drive", {31'h0, abort_drive}, {31'h0, e_drv});
        end
        check_regs(ctx);
        @(negedge clk);
        wr_valid = 0; xfer_done = 0; xfer_fail = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0B1D));
        rst = 1; io_en = 0; bm_en = 0; wr_valid = 0; wr_addr = 0; wr_size = 0;
        wr_data = 0; rd_addr = 0; drive_sel = 0; xfer_done = 0; xfer_fail = 0;
        for (int c = 0; c < 2; c++) begin m_cmd[c] = 8'h00; m_sts[c] = 8'h60; m_ptr[c] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        // R1 reset state
        check_regs("R1 reset");
        chk("R1 reset", "outputs", {28'h0, start_pulse, abort_pulse, acc_err, irq}, 32'h0);

        // R8 gating: each enable alone is not enough
        io_en = 0; bm_en = 1;
        step("R8 io off", 1, 4'd0, 2'd0, 32'h09, 2'b00, 2'b00);
        io_en = 1; bm_en = 0;
        step("R8 bm off", 1, 4'd4, 2'd2, 32'hDEAD_BEEF, 2'b00, 2'b00);
        step("R8 bm off err", 1, 4'd5, 2'd0, 32'h1, 2'b00, 2'b00);
        bm_en = 1;

        // R7 pointer alignment, R9 wrong sizes
        step("R7 ptr0", 1, 4'd4, 2'd2, 32'h1234_5677, 2'b00, 2'b00);
        step("R9 ptr half", 1, 4'd4, 2'd1, 32'hFFFF_FFFF, 2'b00, 2'b00);
        step("R9 ptr mid", 1, 4'd6, 2'd0, 32'hFF, 2'b00, 2'b00);
        step("R9 cmd word", 1, 4'd0, 2'd2, 32'h09, 2'b00, 2'b00);
        step("R9 size3", 1, 4'd2, 2'd3, 32'h60, 2'b00, 2'b00);
        step("R2 reserved wr", 1, 4'd1, 2'd0, 32'hFF, 2'b00, 2'b00);

        // R4 start on channel 0 with drive 1, R3 direction lock
        drive_sel = 2'b01;
        step("R4 start ch0", 1, 4'd0, 2'd0, 32'h09, 2'b00, 2'b00);
        drive_sel = 2'b00;
        step("R3 dir lock", 1, 4'd0, 2'd0, 32'h01, 2'b00, 2'b00);
        step("R6 act ro", 1, 4'd2, 2'd0, 32'hFF, 2'b00, 2'b00);
        step("R5 stop ch0", 1, 4'd0, 2'd0, 32'h00, 2'b00, 2'b00);
        step("R3 dir free", 1, 4'd0, 2'd0, 32'hF6, 2'b00, 2'b00);

        // R10 completion with failure on channel 1, R11 irq, R6 W1C
        drive_sel = 2'b10;
        step("R7 ptr1", 1, 4'd12, 2'd2, 32'h8000_0003, 2'b00, 2'b00);
        step("R4 start ch1", 1, 4'd8, 2'd0, 32'h01, 2'b00, 2'b00);
        step("R10 done ch1", 0, 4'd0, 2'd0, 32'h0, 2'b10, 2'b10);
        step("R6 w0 keeps", 1, 4'd10, 2'd0, 32'h00, 2'b00, 2'b00);
        step("R6 w1c intr", 1, 4'd10, 2'd0, 32'h04, 2'b00, 2'b00);
        step("R6 w1c fail", 1, 4'd10, 2'd0, 32'h02, 2'b00, 2'b00);

        // R10 completion in the same cycle as a write-1-to-clear of intr
        step("R4 restart ch1", 1, 4'd8, 2'd0, 32'h01, 2'b00, 2'b00);
        step("R10 done vs w1c", 1, 4'd10, 2'd0, 32'h04, 2'b10, 2'b00);
        step("R10 done other ch", 1, 4'd0, 2'd0, 32'h01, 2'b10, 2'b00);

        // R2 unaligned read crossing the end of the map
        rd_addr = 4'd14;
        #1;
        chk("R2 tail read", "bytes", rd_data, {16'h0, m_ptr[1][31:16]});

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [1:0] sz;
            logic [1:0] dn;
            int r;
            r = int'($urandom % 10);
            sz = (r < 5) ? 2'd0 : (r < 8) ? 2'd2 : 2'($urandom % 4);
            io_en = ($urandom % 16) != 0;
            bm_en = ($urandom % 16) != 0;
            drive_sel = 2'($urandom % 4);
            dn = {($urandom % 8) == 0, ($urandom % 8) == 0};
            step("RND", ($urandom % 4) != 0, 4'($urandom % 16), sz, $urandom, dn, 2'($urandom % 4));
        end
        summary();
    end

endmodule